// File: doc/BRIEF.md
# Single-Channel DMA Slave Handshake Controller

This block is the card-side half of a single-byte DMA handshake on one channel of a shared expansion bus. It moves one byte at a time. In supply mode it waits for a local producer to hand it a byte, then raises a request. Once the host's acknowledge for this channel goes low, it drives the byte onto the bus while the read strobe is low. In accept mode it requests whenever its outbound holding register is empty. It captures the bus byte on the write strobe during acknowledge, and then presents that byte to a local consumer through a valid/ready pair.

The terminal-count line is shared by every channel, so the block counts it only while its own acknowledge is low. When a transfer that carried terminal count ends, the block stops requesting and pulses a completion output. It stays quiet until the local logic re-arms it.

The local producer has no backpressure. If a second byte arrives before the held one has moved, that is an overrun. An overrun parks the controller in a sticky error state that raises an interrupt line, so host software can recover the stalled channel. Ordinary address-decoded selection is gated off whenever AEN is high.

Top module: `dma_slave_ctl`

## Requirements
- R1: While rst_n is low, drq, irq_err, done, db_oe and lout_valid are all 0, and no byte is held.
- R2: In supply mode (mode_rd=1), a lin_stb pulse loads lin_data into the holding register on that edge, and drq rises one clock edge later. In accept mode (mode_rd=0), drq is high whenever no captured byte is waiting on the local output.
- R3: Once dack_n has been sampled low while drq is high, drq is 0 from the next cycle. It is raised again only after dack_n has returned high and a new byte (supply) or an empty output register (accept) is present.
- R4: db_oe is 1 only when dack_n is low, ior_n is low, mode_rd is 1 and the controller is in a transfer. db_out then carries the held byte. Neither iow_n nor ior_n without acknowledge ever enables the driver.
- R5: In accept mode, db_in is captured while dack_n and iow_n are both low. After dack_n rises, the byte appears on lout_data with lout_valid=1. It is held stable, and no new request is made, until a cycle with lout_ready=1.
- R6: tc is counted only while dack_n is low during a request or transfer. A tc pulse with dack_n high has no effect.
- R7: When a transfer in which tc was seen ends (dack_n rises), done is 1 for exactly one cycle. drq then stays 0 until arm is pulsed. arm also discards any byte held in either direction.
- R8: In supply mode, a lin_stb while a byte is still held (and not leaving in that same cycle) sets irq_err on the next edge. irq_err stays 1 with drq 0 until arm. In accept mode lin_stb is ignored.
- R9: card_sel equals sel_hit while aen is 0 and is 0 whenever aen is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rd | input | 1 | 1: card supplies bytes to host; 0: card accepts bytes (change only while idle) |
| arm | input | 1 | Re-arm pulse leaving the done or error state |
| lin_stb | input | 1 | Local byte available strobe (no backpressure) |
| lin_data | input | DATA_W | Local byte to send |
| lout_data | output | DATA_W | Byte received from the bus |
| lout_valid | output | 1 | lout_data holds a received byte |
| lout_ready | input | 1 | Local consumer takes the received byte |
| aen | input | 1 | Bus address-enable (high during DMA cycles) |
| sel_hit | input | 1 | Address decoder match for ordinary access |
| card_sel | output | 1 | Ordinary selection, gated by aen |
| dack_n | input | 1 | This channel's acknowledge, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| tc | input | 1 | Shared terminal-count line |
| drq | output | 1 | DMA request for this channel |
| db_in | input | DATA_W | Bus data seen by the card |
| db_out | output | DATA_W | Bus data driven by the card |
| db_oe | output | 1 | Bus driver enable |
| irq_err | output | 1 | Overrun error interrupt (sticky) |
| done | output | 1 | One-cycle block-complete pulse |

## Verification
A wrong state shows up at the drq pin within one clock edge. A controller stuck in the transfer state never re-raises the request. One that misses the acknowledge keeps requesting during the host's cycle. A lost terminal-count flag shows as a fresh request where done should have pulsed. The scoreboard compares every byte that leaves on the bus or on the local output against the bytes the bench sent, in order. A byte dropped by a wrong buffer flag therefore shows as an empty-queue or mismatch failure at the next transfer. An overrun that fails to reach the error state shows as a missing irq_err one edge after the second strobe.

// File: rtl/dma_slv_pkg.sv
package dma_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_XFER = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } dma_st_t;
endpackage

// File: rtl/dma_slv_buf.sv
module dma_slv_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              src_stb,
  input  logic [DATA_W-1:0] src_d,
  input  logic              src_take,
  output logic              src_full,
  output logic [DATA_W-1:0] src_q,
  output logic              ovr,
  input  logic              snk_cap,
  input  logic [DATA_W-1:0] snk_d,
  input  logic              snk_commit,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_q
);
  logic src_load;

  assign src_load = src_stb & (~src_full | src_take);
  assign ovr      = src_stb & src_full & ~src_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_full <= 1'b0;
    end else if (clr) begin
      src_full <= 1'b0;
    end else if (src_load) begin
      src_full <= 1'b1;
    end else if (src_take) begin
      src_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_load) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snk_q <= '0;
    end else if (snk_cap) begin
      snk_q <= snk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snk_valid <= 1'b0;
    end else if (clr) begin
      snk_valid <= 1'b0;
    end else if (snk_commit) begin
      snk_valid <= 1'b1;
    end else if (snk_ready) begin
      snk_valid <= 1'b0;
    end
  end

  // R5: a waiting received byte stays put until the consumer takes it
  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready && !clr) |=> (snk_valid && $stable(snk_q)));
endmodule

// File: rtl/dma_slv_fsm.sv
module dma_slv_fsm
  import dma_slv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    arm,
  input  logic    mode_rd,
  input  logic    src_full,
  input  logic    snk_valid,
  input  logic    ovr,
  input  logic    dack_n,
  input  logic    tc,
  output dma_st_t state_q,
  output logic    xfer_end,
  output logic    clr,
  output logic    done_q
);
  dma_st_t state_d;
  logic    tc_hit_q;
  logic    tc_hit_d;
  logic    busy;
  logic    have_work;

  assign busy      = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign have_work = mode_rd ? src_full : ~snk_valid;
  assign xfer_end  = (state_q == ST_XFER) && dack_n;
  assign clr       = arm && ((state_q == ST_DONE) || (state_q == ST_ERR));

  always_comb begin
    tc_hit_d = tc_hit_q;
    if (state_q == ST_IDLE) begin
      tc_hit_d = 1'b0;
    end else if (busy && !dack_n && tc) begin
      tc_hit_d = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (have_work) state_d = ST_REQ;
      ST_REQ:  if (!dack_n) state_d = ST_XFER;
      ST_XFER: if (dack_n) state_d = tc_hit_q ? ST_DONE : ST_IDLE;
      ST_DONE: if (arm) state_d = ST_IDLE;
      ST_ERR:  if (arm) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (ovr && (busy || state_q == ST_IDLE)) begin
      state_d = ST_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tc_hit_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      tc_hit_q <= tc_hit_d;
      done_q   <= (state_q == ST_XFER) && (state_d == ST_DONE);
    end
  end

  // R8: an overrun while active lands in the error state on the next edge
  a_r8_ovr_to_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && (busy || state_q == ST_IDLE)) |=> (state_q == ST_ERR));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: after completion no request until re-armed
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !arm) |=> (state_q == ST_DONE));
endmodule

// File: rtl/dma_slave_ctl.sv
module dma_slave_ctl
  import dma_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rd,
  input  logic              arm,
  input  logic              lin_stb,
  input  logic [DATA_W-1:0] lin_data,
  output logic [DATA_W-1:0] lout_data,
  output logic              lout_valid,
  input  logic              lout_ready,
  input  logic              aen,
  input  logic              sel_hit,
  output logic              card_sel,
  input  logic              dack_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              tc,
  output logic              drq,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic              irq_err,
  output logic              done
);
  dma_st_t state;
  logic    xfer_end;
  logic    clr;
  logic    src_full;
  logic    ovr;
  logic    acked;
  logic    src_stb;

  assign acked   = ~dack_n && ((state == ST_REQ) || (state == ST_XFER));
  assign src_stb = lin_stb & mode_rd;

  dma_slv_buf #(.DATA_W(DATA_W)) i_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .src_stb    (src_stb),
    .src_d      (lin_data),
    .src_take   (xfer_end & mode_rd),
    .src_full   (src_full),
    .src_q      (db_out),
    .ovr        (ovr),
    .snk_cap    (acked & ~mode_rd & ~iow_n),
    .snk_d      (db_in),
    .snk_commit (xfer_end & ~mode_rd),
    .snk_ready  (lout_ready),
    .snk_valid  (lout_valid),
    .snk_q      (lout_data)
  );

  dma_slv_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode_rd   (mode_rd),
    .src_full  (src_full),
    .snk_valid (lout_valid),
    .ovr       (ovr),
    .dack_n    (dack_n),
    .tc        (tc),
    .state_q   (state),
    .xfer_end  (xfer_end),
    .clr       (clr),
    .done_q    (done)
  );

  assign drq      = (state == ST_REQ);
  assign irq_err  = (state == ST_ERR);
  assign db_oe    = acked & mode_rd & ~ior_n & src_full;
  assign card_sel = sel_hit & ~aen;

  // R3: acknowledge seen while requesting removes the request next cycle
  a_r3_drq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drq && !dack_n) |-> !drq);

  // R4: bus driver only under acknowledge and read strobe
  a_r4_oe_ack: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> (!dack_n && !ior_n && mode_rd));

  // R8: error state never requests
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !drq);

  // R9: address-enable blocks ordinary selection
  a_r9_sel_aen: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !card_sel);

  // R5: no request while a received byte waits
  a_r5_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rd && $past(lout_valid) && lout_valid) |-> !drq);
endmodule

// File: tb/test_dma_slave_ctl.sv
module test_dma_slave_ctl;
  logic       clk = 1'b0;
  logic       rst_n, mode_rd, arm, lin_stb, lout_ready, aen, sel_hit;
  logic       dack_n, ior_n, iow_n, tc;
  logic [7:0] lin_data, db_in;
  logic [7:0] lout_data, db_out;
  logic       lout_valid, card_sel, drq, db_oe, irq_err, done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  dma_slave_ctl #(.DATA_W(8)) i_dma_slave_ctl (
    .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd), .arm(arm),
    .lin_stb(lin_stb), .lin_data(lin_data), .lout_data(lout_data),
    .lout_valid(lout_valid), .lout_ready(lout_ready), .aen(aen),
    .sel_hit(sel_hit), .card_sel(card_sel), .dack_n(dack_n),
    .ior_n(ior_n), .iow_n(iow_n), .tc(tc), .drq(drq), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .irq_err(irq_err), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: offer a local byte, optionally recording it as expected on the bus
  task automatic push_src(input logic [7:0] b, input bit expect_it);
    step();
    lin_stb  = 1'b1;
    lin_data = b;
    if (expect_it) exp_q.push_back(b);
    step();
    lin_stb = 1'b0;
  endtask

  task automatic wait_drq(input string req);
    int n = 0;
    @(negedge clk);
    while (!drq && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, drq, 1);
  endtask

  task automatic host_cycle(input bit rd, input logic [7:0] b, input bit with_tc);
    step();
    dack_n = 1'b0;
    tc     = with_tc;
    step();
    @(negedge clk);
    chk("R3 drq drops under ack", drq, 0);
    step();
    if (rd) begin
      ior_n = 1'b0;
    end else begin
      iow_n = 1'b0;
      db_in = b;
      exp_q.push_back(b);
    end
    @(negedge clk);
    chk("R4 driver under ack", db_oe, rd ? 1 : 0);
    step();
    ior_n = 1'b1;
    iow_n = 1'b1;
    tc    = 1'b0;
    step();
    dack_n = 1'b1;
  endtask

  task automatic pulse_arm();
    step();
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  // monitor: pop and compare every byte the design hands over
  always @(negedge clk) begin
    if (rst_n && db_oe && !prev_oe) begin
      if (exp_q.size() == 0) chk("R4 unexpected bus byte", db_out, -1);
      else chk("R4 bus byte", db_out, exp_q.pop_front());
    end
    if (rst_n && lout_valid && lout_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected local byte", lout_data, -1);
      else chk("R5 local byte", lout_data, exp_q.pop_front());
    end
    prev_oe <= db_oe;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_rd = 1'b1; arm = 1'b0; lin_stb = 1'b0; lin_data = '0;
    lout_ready = 1'b0; aen = 1'b0; sel_hit = 1'b0; dack_n = 1'b1;
    ior_n = 1'b1; iow_n = 1'b1; tc = 1'b0; db_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 drq", drq, 0);
    chk("R1 irq_err", irq_err, 0);
    chk("R1 done", done, 0);
    chk("R1 db_oe", db_oe, 0);
    chk("R1 lout_valid", lout_valid, 0);
    step();
    rst_n = 1'b1;

    // R9 selection gating
    sel_hit = 1'b1; #2;
    chk("R9 sel without aen", card_sel, 1);
    aen = 1'b1; #2;
    chk("R9 sel with aen", card_sel, 0);
    sel_hit = 1'b0; aen = 1'b0;

    // R2/R3/R4 supply transfer
    repeat (3) @(negedge clk);
    chk("R2 no request when empty", drq, 0);
    push_src(8'hA5, 1'b1);
    @(negedge clk);
    chk("R2 drq one edge after load", drq, 0);
    wait_drq("R2 request raised");
    step();
    ior_n = 1'b0;
    @(negedge clk);
    chk("R4 read strobe without ack", db_oe, 0);
    step();
    ior_n = 1'b1;
    host_cycle(1'b1, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    chk("R3 no re-request without data", drq, 0);
    chk("R6 no done", done, 0);

    // R6 tc ignored outside ack
    push_src(8'h3C, 1'b1);
    wait_drq("R2 second request");
    step();
    tc = 1'b1;
    step();
    tc = 1'b0;
    host_cycle(1'b1, 8'h00, 1'b0);
    step();
    @(negedge clk);
    chk("R6 stray tc gives no done", done, 0);
    push_src(8'h7E, 1'b1);
    wait_drq("R6 still requesting after stray tc");

    // R7 terminal count
    host_cycle(1'b1, 8'h00, 1'b1);
    step();
    @(negedge clk);
    chk("R7 done pulse", done, 1);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    push_src(8'h11, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 quiet after done", drq, 0);
    pulse_arm();
    repeat (5) @(negedge clk);
    chk("R7 arm discards held byte", drq, 0);

    // R8 overrun
    push_src(8'h42, 1'b0);
    wait_drq("R8 request before overrun");
    push_src(8'h43, 1'b0);
    @(negedge clk);
    chk("R8 irq_err set", irq_err, 1);
    chk("R8 no request in error", drq, 0);
    repeat (5) @(negedge clk);
    chk("R8 irq_err sticky", irq_err, 1);
    pulse_arm();
    @(negedge clk);
    chk("R8 arm clears error", irq_err, 0);
    repeat (3) @(negedge clk);
    chk("R8 arm drops held byte", drq, 0);

    // R5 accept mode
    step();
    mode_rd = 1'b1;
    mode_rd = 1'b0;
    wait_drq("R2 accept mode request");
    host_cycle(1'b0, 8'h9C, 1'b0);
    step();
    @(negedge clk);
    chk("R5 byte presented", lout_valid, 1);
    push_src(8'h55, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 no request while holding", drq, 0);
    chk("R8 strobe ignored in accept mode", irq_err, 0);
    chk("R5 byte still valid", lout_valid, 1);
    step();
    lout_ready = 1'b1;
    step();
    lout_ready = 1'b0;
    wait_drq("R5 request after drain");
    host_cycle(1'b0, 8'hE7, 1'b1);
    step();
    @(negedge clk);
    chk("R7 done in accept mode", done, 1);
    step();
    lout_ready = 1'b1;
    step();
    lout_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 no request after done", drq, 0);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule